// File: doc/BRIEF.md
# Address-Dependent Access Speed Sequencer

This block sits between a processor core and its memory bus and decides how long each bus access takes. When a request arrives while the block is idle, it decodes the 24-bit address into a cost in master-clock cycles. The upper byte of the address is the bank and the next byte is the page. The decode has four speed classes: 6, 8 and 12 cycles, plus a fixed 4-cycle class for DMA. For part of the address space, a fast-memory enable input chooses between 6 and 8 cycles. The block then holds the access for that cost and reports its progress on a phase output.

One clock of this block stands for one step of the master clock, and each step is two master cycles. An access of cost C therefore lasts C/2 clocks. A CPU read waits C-4 master cycles before its data is sampled and then spends 4 more cycles in a data phase. A CPU write waits the full cost before it is committed and has no data phase. A DMA access always lasts 4 master cycles, whatever the address, and follows the write shape. The block pulses one strobe when data is sampled or committed. It pulses a done signal in the final clock of the access.

Top module: `access_speed_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `phase` is 0 (idle), `xfer` and `done` are 0, and `speed` is 0. `phase` encodes 0 as idle, 1 as setup and 2 as data.
- R2: `req` is taken only when `phase` is idle. A request raised during an access changes neither its timing nor `speed`.
- R3: For a CPU access, bank values 0x40 to 0x7F (address bits [23:16]) always cost 8.
- R4: For a CPU access, bank values 0xC0 to 0xFF cost 6 when `fast_en` is 1 and 8 when it is 0.
- R5: For a CPU access in banks 0x00 to 0x3F and 0x80 to 0xBF, the page (address bits [15:8]) sets the cost as follows: 0x00–0x1F cost 8, 0x20–0x3F cost 6, 0x40–0x41 cost 12, 0x42–0x5F cost 6 and 0x60–0x7F cost 8.
- R6: A page of 0x80 or above costs 8 in banks 0x00–0x3F. In banks 0x80–0xBF it costs 6 with `fast_en` 1 and 8 with `fast_en` 0.
- R7: A CPU read (`is_write`=0, `is_dma`=0) spends (C-4)/2 clocks in setup and then 2 clocks in data. `xfer` is high in the last setup clock.
- R8: A CPU write spends all C/2 clocks in setup and none in data. `xfer` and `done` are both high in the last clock.
- R9: A DMA access (`is_dma`=1) costs 4 whatever the address and direction: 2 clocks of setup, with `xfer` and `done` in the second.
- R10: An accepted access sets `speed` to its cost from the next clock and keeps it until the next accepted request. The access stays busy for C/2 clocks. `done` is high in exactly the last of them, and `phase` is idle in the following clock.
- R11: `fast_en` is taken only in the clock a request is accepted. Changing it during an access alters neither its cost nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one master step (two master cycles) per period |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when idle |
| is_write | input | 1 | 1 for a write, 0 for a read |
| is_dma | input | 1 | 1 for a DMA access (fixed cost) |
| addr | input | 24 | Access address: bank in [23:16], page in [15:8] |
| fast_en | input | 1 | Enables the fast cost for switchable regions |
| phase | output | 2 | 0 idle, 1 setup, 2 data |
| xfer | output | 1 | Pulse when data is sampled or committed |
| done | output | 1 | Pulse in the last clock of an access |
| speed | output | 4 | Cost in master cycles of the current or last access |

## Verification
The bench runs addresses from each bank group and each page band, including the single-page 12-cycle band and both ends of the ranges. This separates a wrong band edge from a wrong class value. The switchable regions are run with `fast_en` both set and clear, which exposes a wrong polarity or a region that ignores the bit. Reads and writes at the same cost expose a swapped setup and data split. DMA accesses sent to a 12-cycle address show whether the fixed cost really overrides the decode. One access has a second request and a `fast_en` flip injected while it runs, which separates sampling at acceptance from live tracking.

// File: rtl/asq_pkg.sv
package asq_pkg;
    parameter int ADDR_W    = 24;
    parameter int COST_W    = 4;
    parameter int COST_FAST = 6;
    parameter int COST_SLOW = 8;
    parameter int COST_XSLOW = 12;
    parameter int COST_DMA  = 4;
    parameter int READ_TAIL = 4;

    localparam int BANK_LSB = ADDR_W - 8;
    localparam int PAGE_LSB = ADDR_W - 16;

    typedef logic [COST_W-1:0] cost_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_DATA  = 2'd2
    } phase_t;

    typedef struct packed {
        cost_t total;
        cost_t setup;
        cost_t cost;
    } plan_t;

    // Cost of a CPU access from bank and page bytes.
    function automatic cost_t region_cost(logic [7:0] bank, logic [7:0] page, logic fast);
        cost_t sw;
        sw = fast ? cost_t'(COST_FAST) : cost_t'(COST_SLOW);
        if (bank[7:6] == 2'b01)      return cost_t'(COST_SLOW);
        if (bank[7:6] == 2'b11)      return sw;
        if (page < 8'h20)            return cost_t'(COST_SLOW);
        if (page < 8'h40)            return cost_t'(COST_FAST);
        if (page < 8'h42)            return cost_t'(COST_XSLOW);
        if (page < 8'h60)            return cost_t'(COST_FAST);
        if (page < 8'h80)            return cost_t'(COST_SLOW);
        if (!bank[7])                return cost_t'(COST_SLOW);
        return sw;
    endfunction
endpackage

// File: rtl/asq_decode.sv
module asq_decode
    import asq_pkg::*;
(
    input  logic [7:0] bank,
    input  logic [7:0] page,
    input  logic       fast_en,
    input  logic       is_dma,
    input  logic       is_write,
    output plan_t      plan
);
    cost_t c;

    always_comb begin
        c = is_dma ? cost_t'(COST_DMA) : region_cost(bank, page, fast_en);
        plan.cost  = c;
        plan.total = c >> 1;
        if (!is_write && !is_dma)
            plan.setup = (c - cost_t'(READ_TAIL)) >> 1;
        else
            plan.setup = c >> 1;
    end
endmodule

// File: rtl/asq_timer.sv
module asq_timer
    import asq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  plan_t  plan,
    output phase_t phase,
    output logic   xfer,
    output logic   done,
    output cost_t  speed
);
    phase_t phase_q;
    cost_t  cnt_q;
    plan_t  plan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            plan_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= cost_t'(1);
                        plan_q  <= plan;
                    end
                end
                default: begin
                    if (cnt_q == plan_q.total) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q   <= cnt_q + cost_t'(1);
                        phase_q <= (cnt_q >= plan_q.setup) ? PH_DATA : PH_SETUP;
                    end
                end
            endcase
        end
    end

    assign phase = phase_q;
    assign speed = plan_q.cost;
    assign xfer  = (phase_q == PH_SETUP) && (cnt_q == plan_q.setup);
    assign done  = (phase_q != PH_IDLE) && (cnt_q == plan_q.total);
endmodule

// File: rtl/access_speed_seq.sv
module access_speed_seq
    import asq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              is_write,
    input  logic              is_dma,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast_en,
    output logic [1:0]        phase,
    output logic              xfer,
    output logic              done,
    output logic [COST_W-1:0] speed
);
    plan_t  plan;
    phase_t ph;

    asq_decode u_decode (
        .bank     (addr[BANK_LSB +: 8]),
        .page     (addr[PAGE_LSB +: 8]),
        .fast_en  (fast_en),
        .is_dma   (is_dma),
        .is_write (is_write),
        .plan     (plan)
    );

    asq_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .plan  (plan),
        .phase (ph),
        .xfer  (xfer),
        .done  (done),
        .speed (speed)
    );

    assign phase = ph;
endmodule

// File: rtl/asq_chk.sv
module asq_chk
    import asq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              is_dma,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        phase,
    input logic              xfer,
    input logic              done,
    input logic [COST_W-1:0] speed
);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (phase == 2'd0));

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase != 2'd0));

    // R2
    busy_speed_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |=> $stable(speed));

    // R7
    no_data_first_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |=> (phase != 2'd2));

    // R7
    xfer_setup_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (phase == 2'd1));

    // R9
    dma_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && req && is_dma) |=> (speed == COST_W'(COST_DMA)));

    // R3
    slow_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && req && !is_dma && addr[ADDR_W-1 -: 2] == 2'b01)
        |=> (speed == COST_W'(COST_SLOW)));
endmodule

bind access_speed_seq asq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .is_dma (is_dma),
    .addr   (addr),
    .phase  (phase),
    .xfer   (xfer),
    .done   (done),
    .speed  (speed)
);

// File: tb/access_speed_seq_bench.sv
module access_speed_seq_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        req = 0;
    logic        is_write = 0;
    logic        is_dma = 0;
    logic [23:0] addr = '0;
    logic        fast_en = 0;
    logic [1:0]  phase;
    logic        xfer;
    logic        done;
    logic [3:0]  speed;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    access_speed_seq u_access_speed_seq (
        .clk(clk), .rst(rst), .req(req), .is_write(is_write), .is_dma(is_dma),
        .addr(addr), .fast_en(fast_en), .phase(phase), .xfer(xfer),
        .done(done), .speed(speed)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_cost(input logic [23:0] a, input bit f, input bit d);
        int b, p;
        b = int'(a[23:16]);
        p = int'(a[15:8]);
        if (d) return 4;
        if (b >= 'h40 && b <= 'h7F) return 8;
        if (b >= 'hC0) return f ? 6 : 8;
        if (p <= 'h1F) return 8;
        if (p <= 'h3F) return 6;
        if (p <= 'h41) return 12;
        if (p <= 'h5F) return 6;
        if (p <= 'h7F) return 8;
        if (b <= 'h3F) return 8;
        return f ? 6 : 8;
    endfunction

    task automatic run_access(input string tag, input logic [23:0] a, input bit wr,
                              input bit d, input bit f, input bit disturb);
        int c, tot, su, nsu, nda, xat, dat, ndone, k;
        string ttag;
        c   = ref_cost(a, f, d);
        tot = c / 2;
        su  = (!wr && !d) ? (c - 4) / 2 : tot;
        ttag = d ? "R9" : (wr ? "R8" : "R7");
        nsu = 0; nda = 0; xat = 0; dat = 0; ndone = 0; k = 1;
        @(negedge clk);
        req = 1; addr = a; is_write = wr; is_dma = d; fast_en = f;
        @(negedge clk);
        req = 0;
        while (phase != 2'd0 && k < 32) begin
            if (phase == 2'd1) nsu++;
            if (phase == 2'd2) nda++;
            if (xfer) xat = k;
            if (done) begin dat = k; ndone++; end
            if (k == 1) chk(tag, "speed", int'(speed), c);
            if (disturb && k == 1) begin
                // R2 / R11: second request and fast_en flip mid-access
                req = 1; addr = 24'h400000; is_write = 1; fast_en = ~f;
            end
            if (disturb && k == 2) req = 0;
            @(negedge clk);
            k++;
        end
        chk("R10", "busy clocks", k - 1, tot);
        chk(ttag, "setup clocks", nsu, su);
        chk(ttag, "data clocks", nda, tot - su);
        chk(ttag, "xfer clock", xat, su);
        chk("R10", "done clock", dat, tot);
        chk("R10", "done count", ndone, 1);
        chk("R10", "speed held when idle", int'(speed), c);
        chk("R10", "done low when idle", int'(done), 0);
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "phase in reset", int'(phase), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "phase", int'(phase), 0);
        chk("R1", "xfer", int'(xfer), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "speed", int'(speed), 0);
    endtask

    task automatic t_banks;
        run_access("R3", 24'h401234, 0, 0, 1, 0);
        run_access("R3", 24'h7FFFFF, 1, 0, 1, 0);
        run_access("R4", 24'hC00000, 0, 0, 1, 0);
        run_access("R4", 24'hFF8000, 1, 0, 0, 0);
        run_access("R4", 24'hE04100, 0, 0, 0, 0);
    endtask

    task automatic t_pages;
        run_access("R5", 24'h001F00, 0, 0, 1, 0);
        run_access("R5", 24'h002000, 0, 0, 0, 0);
        run_access("R5", 24'h3F3FFF, 1, 0, 0, 0);
        run_access("R5", 24'h004016, 0, 0, 1, 0);
        run_access("R5", 24'h8041FF, 1, 0, 1, 0);
        run_access("R5", 24'h804200, 1, 0, 0, 0);
        run_access("R5", 24'h005FFF, 0, 0, 1, 0);
        run_access("R5", 24'hBF6000, 0, 0, 1, 0);
        run_access("R5", 24'h007FFF, 1, 0, 1, 0);
    endtask

    task automatic t_upper;
        run_access("R6", 24'h008000, 0, 0, 1, 0);
        run_access("R6", 24'h3FFFFF, 1, 0, 1, 0);
        run_access("R6", 24'h80FFFF, 0, 0, 1, 0);
        run_access("R6", 24'hBF8000, 0, 0, 0, 0);
    endtask

    task automatic t_dma;
        run_access("R9", 24'h004000, 0, 1, 0, 0);
        run_access("R9", 24'h7E0000, 1, 1, 1, 0);
    endtask

    task automatic t_ignore;
        // R2, R11: cost 6 read; injected request and fast_en flip must not matter
        run_access("R11", 24'h808000, 0, 0, 1, 1);
        chk("R2", "phase idle after disturbed access", int'(phase), 0);
        run_access("R2", 24'h004100, 1, 0, 0, 1);
    endtask

    initial begin
        t_reset;
        t_banks;
        t_pages;
        t_upper;
        t_dma;
        t_ignore;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule